// File: doc/BRIEF.md
# Accessory Bus Block Bridge

This block turns one 32-byte block request from a controller's command layer into a run of byte accesses on a parallel accessory port. The port has a 16-bit address, a byte-wide data path in each direction with a drive enable, an active-low write strobe and an active-low read strobe. The host side hands over a direction, a start address, the whole block of write data and a strobe length. It gets back a busy flag, a one-cycle completion pulse and, for reads, the whole block of read data. Each byte is placed at the start address plus its index. A presence input from the accessory slot is sampled when a request is accepted. With nothing plugged in, the bus stays quiet and the request completes at once.

The address space is split into three windows by its two top bits: a storage window over the lower half, an identification window and a motor latch window. The bridge reports which window the current address falls in. Software tells the two accessory kinds apart by writing a block of 0xFE into the identification window and reading it back. A storage accessory answers 0x00 and a vibration accessory answers 0x80. The motor follows bit 0 of the bytes written into the motor window.

Top module: `accbr_bridge`

## Requirements
- R1: While idle, a `start` pulse latches `wr_en`, `start_addr`, `wr_block` and `strobe_len`, and `busy` rises on the next cycle. A `start` raised while `busy` is high is ignored and does not change the transfer in progress.
- R2: With the accessory present, one request makes exactly 32 strobed byte accesses. Access k (k = 0..31) uses address `start_addr + k` modulo 2^16 and byte k of the block, which is bits [8k+7:8k].
- R3: Each strobe stays low for exactly `strobe_len` cycles, with 0 treated as 1. The address stays stable throughout. Between two strobes of one request, both strobes are high for exactly SETUP_CYC + 1 cycles.
- R4: A write lowers only `acc_we_n`. While it is low, `acc_drive` is 1 and `acc_dout` carries the byte for the current address.
- R5: A read lowers only `acc_oe_n` and keeps `acc_drive` at 0. `acc_din` is captured in the last cycle of the strobe, and the block is in `rd_block` when `done` pulses.
- R6: `acc_region` decodes the top two address bits: 0 for the storage window (bit 15 = 0), 1 for the identification window (bits 15:14 = 10), and 2 for the motor window (bits 15:14 = 11).
- R7: If `acc_detect` is 0 when a request is accepted, no strobe falls and `acc_drive` stays 0. A read returns 32 zero bytes, and `done` pulses on the cycle after acceptance.
- R8: `done` is high for exactly one cycle, with `busy` already low. A `start` given in that same cycle is accepted as a new request.
- R9: `acc_we_n` and `acc_oe_n` are never low together, and `acc_drive` is never 1 while `acc_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start | input | 1 | request pulse, taken while idle |
| wr_en | input | 1 | 1 = block write, 0 = block read |
| start_addr | input | 16 | address of byte 0 |
| strobe_len | input | 4 | strobe low time in cycles (0 acts as 1) |
| wr_block | input | 256 | write data, byte k in bits [8k+7:8k] |
| busy | output | 1 | request in progress |
| done | output | 1 | one-cycle completion pulse |
| rd_block | output | 256 | read data, byte k in bits [8k+7:8k] |
| acc_detect | input | 1 | accessory present |
| acc_addr | output | 16 | accessory address |
| acc_dout | output | 8 | data toward the accessory |
| acc_din | input | 8 | data from the accessory |
| acc_drive | output | 1 | enable for the outgoing data driver |
| acc_we_n | output | 1 | active-low write strobe |
| acc_oe_n | output | 1 | active-low read strobe |
| acc_region | output | 2 | window of the current address |

## Verification
Two functions can fall in the same cycle: the completion pulse of one request and the acceptance of the next. The bench raises `start` in the very cycle where it sees `done`. It expects `busy` on the next cycle and a full second run of strobes at the new address, and afterwards both blocks must read back intact. A related collision is a `start` pulsed in the middle of a busy write. It is judged by every strobe still landing on the first request's addresses and data, with exactly 32 strobes.

// File: rtl/accbr_pkg.sv
package accbr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_PULSE = 2'd2,
    ST_GAP   = 2'd3
  } acc_state_e;

  typedef enum logic [1:0] {
    RG_STORE = 2'd0,
    RG_IDENT = 2'd1,
    RG_MOTOR = 2'd2
  } acc_region_e;

  function automatic acc_region_e region_of(input logic top_bit, input logic next_bit);
    if (!top_bit)      return RG_STORE;
    else if (!next_bit) return RG_IDENT;
    else               return RG_MOTOR;
  endfunction

endpackage

// File: rtl/accbr_rst_sync.sv
module accbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/accbr_seq.sv
module accbr_seq
  import accbr_pkg::*;
#(
  parameter int BLOCK_BYTES = 32,
  parameter int SETUP_CYC   = 1,
  parameter int LEN_W       = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic                           detect,
  input  logic [LEN_W-1:0]               strobe_len,
  output acc_state_e                     state,
  output logic [$clog2(BLOCK_BYTES)-1:0] byte_idx,
  output logic                           launch,
  output logic                           capture,
  output logic                           busy,
  output logic                           done
);

  localparam int IDX_W = $clog2(BLOCK_BYTES);
  localparam int SW    = $clog2(SETUP_CYC + 1);
  localparam int CNT_W = (LEN_W > SW) ? LEN_W : SW;
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(BLOCK_BYTES - 1);
  localparam logic [CNT_W-1:0] SETUP_END = CNT_W'(SETUP_CYC - 1);

  acc_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  pulse_end;

  assign pulse_end = CNT_W'(len_q) - CNT_W'(1);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    done_d  = 1'b0;
    launch  = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          launch = 1'b1;
          len_d  = (strobe_len == '0) ? LEN_W'(1) : strobe_len;
          idx_d  = '0;
          cnt_d  = '0;
          if (detect) state_d = ST_ADDR;
          else        done_d  = 1'b1;
        end
      end
      ST_ADDR: begin
        if (cnt_q == SETUP_END) begin
          state_d = ST_PULSE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_PULSE: begin
        if (cnt_q == pulse_end) begin
          capture = 1'b1;
          state_d = ST_GAP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_GAP: begin
        if (idx_q == LAST_IDX) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          idx_d   = idx_q + IDX_W'(1);
          state_d = ST_ADDR;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      len_q   <= LEN_W'(1);
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      done_q  <= done_d;
    end
  end

  assign state    = state_q;
  assign byte_idx = idx_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  absent_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start && !detect) |=> (done && state_q == ST_IDLE));

  // R3
  setup_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP) |=> (state_q == ST_ADDR || state_q == ST_IDLE));

endmodule

// File: rtl/accbr_dp.sv
module accbr_dp #(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           launch,
  input  logic                           capture,
  input  logic                           busy,
  input  logic                           start,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              start_addr,
  input  logic [BLOCK_BYTES*8-1:0]       wr_block,
  input  logic [$clog2(BLOCK_BYTES)-1:0] byte_idx,
  input  logic [7:0]                     acc_din,
  output logic                           dir_wr,
  output logic [ADDR_W-1:0]              acc_addr,
  output logic [7:0]                     acc_dout,
  output logic [BLOCK_BYTES*8-1:0]       rd_block
);

  localparam int BLK_W = BLOCK_BYTES * 8;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [BLK_W-1:0]  wdat_q, wdat_d;
  logic [BLK_W-1:0]  rdat_q, rdat_d;
  logic              dir_q, dir_d;

  always_comb begin
    base_d = base_q;
    wdat_d = wdat_q;
    dir_d  = dir_q;
    rdat_d = rdat_q;
    if (launch) begin
      base_d = start_addr;
      wdat_d = wr_block;
      dir_d  = wr_en;
      rdat_d = '0;
    end
    if (capture && !dir_q) begin
      rdat_d[byte_idx*8 +: 8] = acc_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      wdat_q <= '0;
      dir_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      base_q <= base_d;
      wdat_q <= wdat_d;
      dir_q  <= dir_d;
      rdat_q <= rdat_d;
    end
  end

  assign dir_wr   = dir_q;
  assign acc_addr = base_q + ADDR_W'(byte_idx);
  assign acc_dout = wdat_q[byte_idx*8 +: 8];
  assign rd_block = rdat_q;

  // R1
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(base_q) && $stable(dir_q)));

endmodule

// File: rtl/accbr_bridge.sv
module accbr_bridge
  import accbr_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 32,
  parameter int SETUP_CYC   = 1,
  parameter int LEN_W       = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        start_addr,
  input  logic [LEN_W-1:0]         strobe_len,
  input  logic [BLOCK_BYTES*8-1:0] wr_block,
  output logic                     busy,
  output logic                     done,
  output logic [BLOCK_BYTES*8-1:0] rd_block,
  input  logic                     acc_detect,
  output logic [ADDR_W-1:0]        acc_addr,
  output logic [7:0]               acc_dout,
  input  logic [7:0]               acc_din,
  output logic                     acc_drive,
  output logic                     acc_we_n,
  output logic                     acc_oe_n,
  output logic [1:0]               acc_region
);

  localparam int IDX_W = $clog2(BLOCK_BYTES);

  logic             rst_n_s;
  acc_state_e       state;
  logic [IDX_W-1:0] byte_idx;
  logic             launch;
  logic             capture;
  logic             dir_wr;
  logic             in_pulse;

  accbr_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  accbr_seq #(
    .BLOCK_BYTES (BLOCK_BYTES),
    .SETUP_CYC   (SETUP_CYC),
    .LEN_W       (LEN_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start      (start),
    .detect     (acc_detect),
    .strobe_len (strobe_len),
    .state      (state),
    .byte_idx   (byte_idx),
    .launch     (launch),
    .capture    (capture),
    .busy       (busy),
    .done       (done)
  );

  accbr_dp #(
    .ADDR_W      (ADDR_W),
    .BLOCK_BYTES (BLOCK_BYTES)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .launch     (launch),
    .capture    (capture),
    .busy       (busy),
    .start      (start),
    .wr_en      (wr_en),
    .start_addr (start_addr),
    .wr_block   (wr_block),
    .byte_idx   (byte_idx),
    .acc_din    (acc_din),
    .dir_wr     (dir_wr),
    .acc_addr   (acc_addr),
    .acc_dout   (acc_dout),
    .rd_block   (rd_block)
  );

  assign in_pulse   = (state == ST_PULSE);
  assign acc_we_n   = !(in_pulse && dir_wr);
  assign acc_oe_n   = !(in_pulse && !dir_wr);
  assign acc_drive  = busy && dir_wr;
  assign acc_region = region_of(acc_addr[ADDR_W-1], acc_addr[ADDR_W-2]);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(!acc_we_n && !acc_oe_n));

  // R9
  drive_contention_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !acc_oe_n |-> !acc_drive);

  // R3
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!acc_we_n || !acc_oe_n) |-> $stable(acc_addr));

endmodule

// File: tb/accbr_bridge_bench.sv
module accbr_bridge_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SETUP_CYC  = 1;
  localparam int NB         = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         wr_en;
  logic [15:0]  start_addr;
  logic [3:0]   strobe_len;
  logic [255:0] wr_block;
  logic         busy, done;
  logic [255:0] rd_block;
  logic         acc_detect;
  logic [15:0]  acc_addr;
  logic [7:0]   acc_dout;
  logic [7:0]   acc_din;
  logic         acc_drive, acc_we_n, acc_oe_n;
  logic [1:0]   acc_region;

  always #(CLK_PERIOD/2) clk = ~clk;

  accbr_bridge #(.SETUP_CYC(SETUP_CYC)) u_accbr_bridge (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
    .start_addr(start_addr), .strobe_len(strobe_len), .wr_block(wr_block),
    .busy(busy), .done(done), .rd_block(rd_block), .acc_detect(acc_detect),
    .acc_addr(acc_addr), .acc_dout(acc_dout), .acc_din(acc_din),
    .acc_drive(acc_drive), .acc_we_n(acc_we_n), .acc_oe_n(acc_oe_n),
    .acc_region(acc_region)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // accessory models: small storage array, identity byte, motor latch
  logic [7:0] mem [0:1023];
  logic       vib_kind;
  logic       motor;

  always_comb begin
    if (!acc_addr[15])     acc_din = mem[acc_addr[9:0]];
    else if (!acc_addr[14]) acc_din = vib_kind ? 8'h80 : 8'h00;
    else                   acc_din = 8'h00;
  end

  // expectations for the running request
  logic         exp_wr;
  logic [15:0]  exp_base;
  logic [255:0] exp_block;
  int           exp_len;
  int           k_seen;
  int           lo_run, hi_run;
  logic         prev_lo;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] region_exp(input logic [15:0] a);
    if (!a[15]) return 2'd0;
    return a[14] ? 2'd2 : 2'd1;
  endfunction

  // monitor, sampling away from the rising edge
  always @(negedge clk) begin
    logic lo;
    if (rst_n) begin
      lo = !acc_we_n || !acc_oe_n;
      if (!acc_we_n) begin
        if (!acc_addr[15]) mem[acc_addr[9:0]] <= acc_dout;
        else if (acc_addr[14]) motor <= acc_dout[0];
      end
      if (lo && !prev_lo) begin
        if (!acc_detect) check(1'b0, "R7", "strobe with accessory absent", 0, 0);
        check(acc_addr == exp_base + 16'(k_seen), "R2", "address", acc_addr, exp_base + 16'(k_seen));
        check(acc_region == region_exp(acc_addr), "R6", "region", acc_region, region_exp(acc_addr));
        if (k_seen > 0)
          check(hi_run == SETUP_CYC + 1, "R3", "gap between strobes", hi_run, SETUP_CYC + 1);
        if (exp_wr) begin
          check(acc_oe_n && acc_drive, "R4", "write strobe pins", {acc_oe_n, acc_drive}, 2'b11);
          check(acc_dout == exp_block[k_seen*8 +: 8], "R4", "write data", acc_dout, exp_block[k_seen*8 +: 8]);
        end else begin
          check(acc_we_n && !acc_drive, "R5", "read strobe pins", {acc_we_n, acc_drive}, 2'b10);
        end
        k_seen = k_seen + 1;
        lo_run = 1;
      end else if (lo) begin
        lo_run = lo_run + 1;
      end
      if (!lo && prev_lo) begin
        check(lo_run == exp_len, "R3", "strobe width", lo_run, exp_len);
        hi_run = 1;
      end else if (!lo) begin
        hi_run = hi_run + 1;
      end
      prev_lo = lo;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  function automatic logic [255:0] pattern(input int base, input int len);
    logic [255:0] b;
    for (int i = 0; i < NB; i++) b[i*8 +: 8] = 8'(base ^ (base >> 8) ^ (i * 37) ^ (len * 11));
    return b;
  endfunction

  function automatic logic [255:0] fill(input logic [7:0] v);
    logic [255:0] b;
    for (int i = 0; i < NB; i++) b[i*8 +: 8] = v;
    return b;
  endfunction

  task automatic arm(input bit wr, input logic [15:0] a, input logic [255:0] blk, input int len);
    exp_wr = wr; exp_base = a; exp_block = blk;
    exp_len = (len == 0) ? 1 : len;
    k_seen = 0;
    start = 1'b1; wr_en = wr; start_addr = a; wr_block = blk; strobe_len = 4'(len);
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // one whole request; poke > 0 pulses a foreign start that many cycles in
  task automatic xfer(input bit wr, input logic [15:0] a, input logic [255:0] blk,
                      input int len, input int poke);
    arm(wr, a, blk, len);
    @(negedge clk);
    start = 1'b0;
    check(busy == acc_detect, "R1", "busy after accept", busy, acc_detect);
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      start = 1'b1; start_addr = a ^ 16'h0155; wr_block = ~blk; wr_en = !wr;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done();
    check(done, "R8", "done pulse seen", done, 1);
    check(!busy, "R8", "busy low with done", busy, 0);
    check(k_seen == (acc_detect ? NB : 0), acc_detect ? "R2" : "R7", "strobe count",
          k_seen, acc_detect ? NB : 0);
    @(negedge clk);
    check(!done, "R8", "done one cycle", done, 0);
  endtask

  initial begin
    logic [255:0] blk;
    rst_n = 1'b0; start = 1'b0; wr_en = 1'b0; start_addr = '0;
    strobe_len = 4'd1; wr_block = '0; acc_detect = 1'b1; vib_kind = 1'b0;
    motor = 1'b0; prev_lo = 1'b0; lo_run = 0; hi_run = 0; k_seen = 0;
    exp_wr = 1'b0; exp_base = '0; exp_block = '0; exp_len = 1;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state, R9 idle pins
    check(!busy && !done, "R1", "reset busy/done", {busy, done}, 0);
    check(acc_we_n && acc_oe_n && !acc_drive, "R9", "reset strobes",
          {acc_we_n, acc_oe_n, acc_drive}, 3'b110);

    // sweep strobe lengths and start addresses; R2 R3 R4 R5
    for (int len = 0; len <= 4; len++) begin
      for (int b = 0; b < 3; b++) begin
        int base;
        base = b * 16'h0100 + len * 16'h0020 + b * 3;
        xfer(1'b1, 16'(base), pattern(base, len), len, 0);
        xfer(1'b0, 16'(base), '0, len, 0);
        check(rd_block == pattern(base, len), "R5", "read block", rd_block, pattern(base, len));
      end
    end

    // R1: start during a busy write is ignored
    xfer(1'b1, 16'h0200, pattern(16'h0200, 9), 2, 20);
    xfer(1'b0, 16'h0200, '0, 2, 0);
    check(rd_block == pattern(16'h0200, 9), "R1", "block after busy start", rd_block, pattern(16'h0200, 9));

    // R8: start given in the done cycle
    arm(1'b1, 16'h0300, pattern(16'h0300, 5), 1);
    @(negedge clk);
    start = 1'b0;
    wait_done();
    arm(1'b1, 16'h0340, pattern(16'h0340, 6), 3);
    @(negedge clk);
    start = 1'b0;
    check(busy, "R8", "start in done cycle accepted", busy, 1);
    wait_done();
    check(k_seen == NB, "R8", "second request strobes", k_seen, NB);
    @(negedge clk);
    xfer(1'b0, 16'h0300, '0, 1, 0);
    check(rd_block == pattern(16'h0300, 5), "R8", "first block intact", rd_block, pattern(16'h0300, 5));
    xfer(1'b0, 16'h0340, '0, 1, 0);
    check(rd_block == pattern(16'h0340, 6), "R8", "second block intact", rd_block, pattern(16'h0340, 6));

    // R7: accessory absent
    acc_detect = 1'b0;
    xfer(1'b0, 16'h0300, fill(8'hAA), 2, 0);
    check(rd_block == '0, "R7", "absent read zeros", rd_block, 0);
    xfer(1'b1, 16'h0300, fill(8'h5A), 2, 0);
    acc_detect = 1'b1;
    xfer(1'b0, 16'h0300, '0, 2, 0);
    check(rd_block == pattern(16'h0300, 5), "R7", "absent write left storage", rd_block, pattern(16'h0300, 5));

    // R6 identification window, both accessory kinds
    for (int kind = 0; kind < 2; kind++) begin
      vib_kind = kind[0];
      xfer(1'b1, 16'h8000, fill(8'hFE), 1, 0);
      xfer(1'b0, 16'h8000, '0, 1, 0);
      blk = fill(kind ? 8'h80 : 8'h00);
      check(rd_block == blk, "R6", "identity readback", rd_block, blk);
    end

    // R6 motor window
    xfer(1'b1, 16'hC000, fill(8'h01), 1, 0);
    check(motor == 1'b1, "R6", "motor on", motor, 1);
    xfer(1'b1, 16'hC000, fill(8'h00), 1, 0);
    check(motor == 1'b0, "R6", "motor off", motor, 0);

    // R2 address wrap modulo 2^16
    xfer(1'b1, 16'hFFF0, fill(8'h00), 1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule